// File: doc/BRIEF.md
# Breakpoint Value Register Access Guard

This block sits between a coprocessor-style register access port and a small bank of breakpoint value registers. Each request carries a coprocessor number, two opcode fields, two register-number fields, a read/write flag and the current privilege level. The block first checks that the request addresses the breakpoint value bank (coprocessor 14, opc1 0, CRn 0, opc2 4, with the register index in CRm). It then runs a fixed, privilege-dependent priority chain that picks one outcome: undefined, a trap to level 2 in either a 64-bit or a 32-bit style, a trap to level 3, a debug halt, or performing the access.

The chain takes its inputs from straps that say which levels exist and in which style they run, from trap-control bits that higher levels own, from an OS-lock flag, from a halting-allowed flag and from an external-debug trap bit. The storage is read or written only when the outcome is "perform". The outcome is a registered one-hot vector. It comes with a 6-bit exception class for traps and with registered read data, all valid one cycle after the request strobe. Taking the resulting exception is the job of the surrounding core.

Top module: `bkpt_value_access_guard`

## Requirements
- R1: When the strap for 32-bit support at the lowest OS level is low, or CRm is not below the parameter BKPT_COUNT, the outcome is undefined at every privilege level, ahead of every other check.
- R2: Every in-range request from privilege level 0 is undefined.
- R3: At levels 1 and 2, a level-3 trap condition (level 3 present, 64-bit style, access-trap bit set) together with the undefined-priority flag gives undefined. This applies even when level-2 trap bits are also set.
- R4: At level 1, when level 2 is enabled and runs in 64-bit style, either of its two debug trap bits gives the outcome "trap to level 2, 64-bit style" with class 0x05.
- R5: At level 1, when level 2 is enabled and runs in 32-bit style, either of its own two debug trap bits gives "trap to level 2, 32-bit style" with class 0x05. The 64-bit-style bits are then ignored.
- R6: At levels 1 and 2, after the level-2 checks, a level-3 trap condition gives undefined when the secure-debug-disable input is high, and otherwise "trap to level 3" with class 0x05.
- R7: When the OS lock is clear, halting is allowed and the external-debug trap bit is set, and no earlier check has fired, the outcome is a debug halt. In all other cases the access is performed.
- R8: At level 2 the level-2 trap bits have no effect. At level 3 only the halt check can prevent the access.
- R9: A request whose coprocessor, opc1, CRn or opc2 field differs from 14, 0, 0, 4 gets no response and does not change the storage.
- R10: Only a "perform" outcome writes the indexed register or returns its value. Every other outcome, and every write, returns zero read data and leaves the storage unchanged.
- R11: respValid, outcome and excClass are registered and valid in the cycle after the request strobe. Outcome bits: 0 undefined, 1 level-2 trap 64-bit, 2 level-2 trap 32-bit, 3 level-3 trap, 4 halt, 5 perform. excClass is 0x05 for the three traps and 0 otherwise.
- R12: Reset clears respValid, outcome, excClass, read data and every breakpoint value register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request strobe |
| reqWrite | input | 1 | 1 = write, 0 = read |
| coprocNum | input | 4 | Coprocessor number field |
| opcA | input | 3 | First opcode field (opc1) |
| crPrimary | input | 4 | Primary register field (CRn) |
| crIndex | input | 4 | Secondary register field (CRm), register index |
| opcB | input | 3 | Second opcode field (opc2) |
| privLevel | input | 2 | Current privilege level 0..3 |
| wrData | input | 32 | Write data |
| lowLvl32Ok | input | 1 | Lowest OS level supports the 32-bit style |
| lvl2Enabled | input | 1 | Level 2 is enabled |
| lvl2Is64 | input | 1 | Level 2 runs in 64-bit style |
| lvl3Present | input | 1 | Level 3 is implemented |
| lvl3Is64 | input | 1 | Level 3 runs in 64-bit style |
| undefFirst | input | 1 | Level-3 trap becomes early undefined |
| secDbgOff | input | 1 | Secure-debug-disable condition |
| l2ExcTrap64 | input | 1 | Level-2 debug exception trap bit, 64-bit style control |
| l2AccTrap64 | input | 1 | Level-2 debug access trap bit, 64-bit style control |
| l2ExcTrap32 | input | 1 | Level-2 debug exception trap bit, 32-bit style control |
| l2AccTrap32 | input | 1 | Level-2 debug access trap bit, 32-bit style control |
| l3AccTrap | input | 1 | Level-3 debug access trap bit |
| osLocked | input | 1 | OS lock is set |
| haltAllowed | input | 1 | Halting is allowed |
| extDbgTrap | input | 1 | External-debug access trap bit |
| respValid | output | 1 | Response valid |
| outcome | output | 6 | One-hot outcome (see R11) |
| excClass | output | 6 | Exception class for traps |
| rdData | output | 32 | Read data |

## Verification
The priority chain is tried with trap inputs stacked in pairs, so that each test shows which of two competing checks wins. Examples are early-undefined against a level-2 trap, 32-bit-style bits against 64-bit-style bits, and secure-debug-disable against a level-3 trap. The same trap settings are then repeated at each privilege level, which shows which checks that level skips. After each blocked write, a read at level 3 shows that the storage is untouched. A mis-encoded request followed by a read back shows that it produced neither a response nor a write.

// File: rtl/bpg_pkg.sv
package bpg_pkg;
  localparam int IDX_W = 4;
  localparam int DATA_W = 32;
  localparam int OC_W = 6;
  localparam int EC_W = 6;

  localparam int OC_UNDEF = 0;
  localparam int OC_TRAP2_64 = 1;
  localparam int OC_TRAP2_32 = 2;
  localparam int OC_TRAP3 = 3;
  localparam int OC_HALT = 4;
  localparam int OC_DO = 5;

  localparam logic [EC_W-1:0] EC_DEBUG = 6'h05;

  localparam logic [3:0] ENC_COPROC = 4'hE;
  localparam logic [2:0] ENC_OPC_A = 3'd0;
  localparam logic [3:0] ENC_CR_PRI = 4'd0;
  localparam logic [2:0] ENC_OPC_B = 3'd4;

  typedef struct packed {
    logic wrEn;
    logic rdEn;
    logic [IDX_W-1:0] idx;
  } bpgStrobes_t;
endpackage

// File: rtl/bpg_ctrl.sv
module bpg_ctrl
  import bpg_pkg::*;
#(
  parameter int BKPT_COUNT = 6
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  input  logic reqWrite,
  input  logic [3:0] coprocNum,
  input  logic [2:0] opcA,
  input  logic [3:0] crPrimary,
  input  logic [IDX_W-1:0] crIndex,
  input  logic [2:0] opcB,
  input  logic [1:0] privLevel,
  input  logic lowLvl32Ok,
  input  logic lvl2Enabled,
  input  logic lvl2Is64,
  input  logic lvl3Present,
  input  logic lvl3Is64,
  input  logic undefFirst,
  input  logic secDbgOff,
  input  logic l2ExcTrap64,
  input  logic l2AccTrap64,
  input  logic l2ExcTrap32,
  input  logic l2AccTrap32,
  input  logic l3AccTrap,
  input  logic osLocked,
  input  logic haltAllowed,
  input  logic extDbgTrap,
  output bpgStrobes_t strobes,
  output logic respValid,
  output logic [OC_W-1:0] outcome,
  output logic [EC_W-1:0] excClass
);
  localparam logic [IDX_W:0] CNT_LIM = (IDX_W+1)'(BKPT_COUNT);

  logic reqHit;
  logic inRange;
  logic l3TrapOn;
  logic l2Trap64On;
  logic l2Trap32On;
  logic haltOn;
  logic [OC_W-1:0] nextOc;
  logic isTrap;

  // Request decode: only the breakpoint value encoding is answered.
  assign reqHit = reqValid && (coprocNum == ENC_COPROC) && (opcA == ENC_OPC_A)
                  && (crPrimary == ENC_CR_PRI) && (opcB == ENC_OPC_B);
  assign inRange = {1'b0, crIndex} < CNT_LIM;

  assign l3TrapOn = lvl3Present && lvl3Is64 && l3AccTrap;
  assign l2Trap64On = lvl2Enabled && lvl2Is64 && (l2ExcTrap64 || l2AccTrap64);
  assign l2Trap32On = lvl2Enabled && !lvl2Is64 && (l2ExcTrap32 || l2AccTrap32);
  assign haltOn = !osLocked && haltAllowed && extDbgTrap;

  // Fixed priority chain per privilege level.
  always_comb begin
    nextOc = '0;
    if (!lowLvl32Ok || !inRange) begin
      nextOc[OC_UNDEF] = 1'b1;
    end else begin
      unique case (privLevel)
        2'd0: nextOc[OC_UNDEF] = 1'b1;
        2'd1: begin
          if (l3TrapOn && undefFirst) nextOc[OC_UNDEF] = 1'b1;
          else if (l2Trap64On) nextOc[OC_TRAP2_64] = 1'b1;
          else if (l2Trap32On) nextOc[OC_TRAP2_32] = 1'b1;
          else if (l3TrapOn) begin
            if (secDbgOff) nextOc[OC_UNDEF] = 1'b1;
            else nextOc[OC_TRAP3] = 1'b1;
          end
          else if (haltOn) nextOc[OC_HALT] = 1'b1;
          else nextOc[OC_DO] = 1'b1;
        end
        2'd2: begin
          if (l3TrapOn && undefFirst) nextOc[OC_UNDEF] = 1'b1;
          else if (l3TrapOn) begin
            if (secDbgOff) nextOc[OC_UNDEF] = 1'b1;
            else nextOc[OC_TRAP3] = 1'b1;
          end
          else if (haltOn) nextOc[OC_HALT] = 1'b1;
          else nextOc[OC_DO] = 1'b1;
        end
        default: begin
          if (haltOn) nextOc[OC_HALT] = 1'b1;
          else nextOc[OC_DO] = 1'b1;
        end
      endcase
    end
  end

  assign isTrap = nextOc[OC_TRAP2_64] || nextOc[OC_TRAP2_32] || nextOc[OC_TRAP3];

  // Strobes to the datapath act on the same edge that registers the outcome.
  always_comb begin
    strobes.wrEn = reqHit && reqWrite && nextOc[OC_DO];
    strobes.rdEn = reqHit && !reqWrite && nextOc[OC_DO];
    strobes.idx = crIndex;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      outcome <= '0;
      excClass <= '0;
    end else begin
      respValid <= reqHit;
      outcome <= reqHit ? nextOc : '0;
      excClass <= (reqHit && isTrap) ? EC_DEBUG : '0;
    end
  end
endmodule

// File: rtl/bpg_data.sv
module bpg_data
  import bpg_pkg::*;
#(
  parameter int BKPT_COUNT = 6
) (
  input  logic clk,
  input  logic rstN,
  input  bpgStrobes_t strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] valueReg [BKPT_COUNT];
  logic [DATA_W-1:0] muxOut;

  for (genvar g = 0; g < BKPT_COUNT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) valueReg[g] <= '0;
      else if (strobes.wrEn && (strobes.idx == IDX_W'(g))) valueReg[g] <= wrData;
    end
  end

  always_comb begin
    muxOut = '0;
    for (int i = 0; i < BKPT_COUNT; i++) begin
      if (strobes.idx == IDX_W'(i)) muxOut = valueReg[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else rdData <= strobes.rdEn ? muxOut : '0;
  end
endmodule

// File: rtl/bkpt_value_access_guard.sv
module bkpt_value_access_guard
  import bpg_pkg::*;
#(
  parameter int BKPT_COUNT = 6
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  input  logic reqWrite,
  input  logic [3:0] coprocNum,
  input  logic [2:0] opcA,
  input  logic [3:0] crPrimary,
  input  logic [3:0] crIndex,
  input  logic [2:0] opcB,
  input  logic [1:0] privLevel,
  input  logic [31:0] wrData,
  input  logic lowLvl32Ok,
  input  logic lvl2Enabled,
  input  logic lvl2Is64,
  input  logic lvl3Present,
  input  logic lvl3Is64,
  input  logic undefFirst,
  input  logic secDbgOff,
  input  logic l2ExcTrap64,
  input  logic l2AccTrap64,
  input  logic l2ExcTrap32,
  input  logic l2AccTrap32,
  input  logic l3AccTrap,
  input  logic osLocked,
  input  logic haltAllowed,
  input  logic extDbgTrap,
  output logic respValid,
  output logic [5:0] outcome,
  output logic [5:0] excClass,
  output logic [31:0] rdData
);
  bpgStrobes_t strobes;

  bpg_ctrl #(.BKPT_COUNT(BKPT_COUNT)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .coprocNum(coprocNum), .opcA(opcA), .crPrimary(crPrimary),
    .crIndex(crIndex), .opcB(opcB), .privLevel(privLevel),
    .lowLvl32Ok(lowLvl32Ok), .lvl2Enabled(lvl2Enabled), .lvl2Is64(lvl2Is64),
    .lvl3Present(lvl3Present), .lvl3Is64(lvl3Is64), .undefFirst(undefFirst),
    .secDbgOff(secDbgOff), .l2ExcTrap64(l2ExcTrap64), .l2AccTrap64(l2AccTrap64),
    .l2ExcTrap32(l2ExcTrap32), .l2AccTrap32(l2AccTrap32), .l3AccTrap(l3AccTrap),
    .osLocked(osLocked), .haltAllowed(haltAllowed), .extDbgTrap(extDbgTrap),
    .strobes(strobes), .respValid(respValid), .outcome(outcome),
    .excClass(excClass)
  );

  bpg_data #(.BKPT_COUNT(BKPT_COUNT)) data_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .rdData(rdData)
  );
endmodule

// File: rtl/bpg_checker.sv
module bpg_checker #(
  parameter int BKPT_COUNT = 6
) (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic [3:0] coprocNum,
  input logic [2:0] opcA,
  input logic [3:0] crPrimary,
  input logic [3:0] crIndex,
  input logic [2:0] opcB,
  input logic [1:0] privLevel,
  input logic lowLvl32Ok,
  input logic osLocked,
  input logic haltAllowed,
  input logic extDbgTrap,
  input logic respValid,
  input logic [5:0] outcome,
  input logic [5:0] excClass,
  input logic [31:0] rdData
);
  logic addressed;
  logic idxOk;
  assign addressed = reqValid && coprocNum == 4'hE && opcA == 3'd0
                     && crPrimary == 4'd0 && opcB == 3'd4;
  assign idxOk = {1'b0, crIndex} < 5'(BKPT_COUNT);

  p_onehot_r11: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $countones(outcome) == 1);

  p_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    !respValid |-> (outcome == 6'd0 && excClass == 6'd0));

  p_class_r11: assert property (@(posedge clk) disable iff (!rstN)
    respValid && (outcome[1] || outcome[2] || outcome[3]) |-> excClass == 6'h05);

  p_gate_r1: assert property (@(posedge clk) disable iff (!rstN)
    addressed && (!lowLvl32Ok || !idxOk) |=> outcome[0]);

  p_el0_r2: assert property (@(posedge clk) disable iff (!rstN)
    addressed && privLevel == 2'd0 |=> outcome[0]);

  p_l3_halt_r8: assert property (@(posedge clk) disable iff (!rstN)
    addressed && privLevel == 2'd3 && lowLvl32Ok && idxOk
    && !osLocked && haltAllowed && extDbgTrap |=> outcome[4]);

  p_nohit_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !addressed |=> !respValid);

  p_rdzero_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(respValid && outcome[5]) |-> rdData == 32'd0);
endmodule

bind bkpt_value_access_guard bpg_checker #(.BKPT_COUNT(BKPT_COUNT)) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .coprocNum(coprocNum),
  .opcA(opcA), .crPrimary(crPrimary), .crIndex(crIndex), .opcB(opcB),
  .privLevel(privLevel), .lowLvl32Ok(lowLvl32Ok), .osLocked(osLocked),
  .haltAllowed(haltAllowed), .extDbgTrap(extDbgTrap), .respValid(respValid),
  .outcome(outcome), .excClass(excClass), .rdData(rdData)
);

// File: tb/bkpt_value_access_guard_tb_top.sv
module bkpt_value_access_guard_tb_top;
  localparam logic [5:0] UNDEF = 6'b000001;
  localparam logic [5:0] T2_64 = 6'b000010;
  localparam logic [5:0] T2_32 = 6'b000100;
  localparam logic [5:0] T3 = 6'b001000;
  localparam logic [5:0] HALT = 6'b010000;
  localparam logic [5:0] DOIT = 6'b100000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [3:0] coprocNum = 4'hE;
  logic [2:0] opcA = 3'd0;
  logic [3:0] crPrimary = 4'd0;
  logic [3:0] crIndex = 4'd0;
  logic [2:0] opcB = 3'd4;
  logic [1:0] privLevel = 2'd3;
  logic [31:0] wrData = 32'd0;
  logic lowLvl32Ok, lvl2Enabled, lvl2Is64, lvl3Present, lvl3Is64, undefFirst;
  logic secDbgOff, l2ExcTrap64, l2AccTrap64, l2ExcTrap32, l2AccTrap32;
  logic l3AccTrap, osLocked, haltAllowed, extDbgTrap;
  logic respValid;
  logic [5:0] outcome, excClass;
  logic [31:0] rdData;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  bkpt_value_access_guard #(.BKPT_COUNT(6)) dut_i (.*);

  task automatic quiet();
    lowLvl32Ok = 1; lvl2Enabled = 0; lvl2Is64 = 0; lvl3Present = 0; lvl3Is64 = 0;
    undefFirst = 0; secDbgOff = 0; l2ExcTrap64 = 0; l2AccTrap64 = 0;
    l2ExcTrap32 = 0; l2AccTrap32 = 0; l3AccTrap = 0; osLocked = 1;
    haltAllowed = 0; extDbgTrap = 0;
    coprocNum = 4'hE; opcA = 3'd0; crPrimary = 4'd0; opcB = 3'd4;
  endtask

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One request strobe; outputs are sampled one cycle later at the falling edge.
  task automatic acc(bit w, int idx, int pv, logic [31:0] d);
    @(negedge clk);
    reqValid = 1; reqWrite = w; crIndex = 4'(idx); privLevel = 2'(pv); wrData = d;
    @(negedge clk);
    reqValid = 0;
  endtask

  task automatic expect_resp(string tag, logic [5:0] oc, logic [5:0] ec, logic [31:0] rd);
    chk({tag, " valid"}, 64'(respValid), 64'd1);
    chk({tag, " outcome"}, 64'(outcome), 64'(oc));
    chk({tag, " class"}, 64'(excClass), 64'(ec));
    chk({tag, " rdData"}, 64'(rdData), 64'(rd));
  endtask

  task automatic readback(string tag, int idx, logic [31:0] exp);
    quiet();
    acc(0, idx, 3, 32'd0);
    expect_resp(tag, DOIT, 6'd0, exp);
  endtask

  task automatic t_reset();
    chk("R12 respValid after reset", 64'(respValid), 64'd0);
    chk("R12 outcome after reset", 64'(outcome), 64'd0);
    readback("R12 reg5 reset value", 5, 32'd0);
  endtask

  task automatic t_perform();
    quiet();
    acc(1, 2, 1, 32'hA5A5_1234);
    expect_resp("R10 write at level1", DOIT, 6'd0, 32'd0);
    readback("R10 R11 readback reg2", 2, 32'hA5A5_1234);
    acc(1, 5, 2, 32'h0BAD_F00D);
    readback("R10 readback reg5", 5, 32'h0BAD_F00D);
    readback("R10 reg2 untouched", 2, 32'hA5A5_1234);
  endtask

  task automatic t_gate();
    quiet();
    acc(0, 6, 3, 0);
    expect_resp("R1 index 6 out of range", UNDEF, 6'd0, 32'd0);
    quiet(); lowLvl32Ok = 0; haltAllowed = 1; extDbgTrap = 1; osLocked = 0;
    acc(1, 2, 3, 32'h1);
    expect_resp("R1 low level strap off", UNDEF, 6'd0, 32'd0);
    readback("R1 R10 no write when gated", 2, 32'hA5A5_1234);
  endtask

  task automatic t_el0();
    quiet();
    acc(0, 2, 0, 0);
    expect_resp("R2 level0 read", UNDEF, 6'd0, 32'd0);
  endtask

  task automatic t_early();
    quiet(); lvl3Present = 1; lvl3Is64 = 1; l3AccTrap = 1; undefFirst = 1;
    lvl2Enabled = 1; lvl2Is64 = 1; l2AccTrap64 = 1;
    acc(0, 2, 1, 0);
    expect_resp("R3 early undef over l2 trap", UNDEF, 6'd0, 32'd0);
    acc(0, 2, 2, 0);
    expect_resp("R3 early undef at level2", UNDEF, 6'd0, 32'd0);
  endtask

  task automatic t_l2trap();
    quiet(); lvl2Enabled = 1; lvl2Is64 = 1; l2ExcTrap64 = 1;
    lvl3Present = 1; lvl3Is64 = 1; l3AccTrap = 1;
    acc(1, 2, 1, 32'hDEAD_0000);
    expect_resp("R4 64-bit style trap", T2_64, 6'h05, 32'd0);
    readback("R4 R10 trapped write dropped", 2, 32'hA5A5_1234);
    quiet(); lvl2Enabled = 1; lvl2Is64 = 0; l2AccTrap32 = 1; l2AccTrap64 = 1;
    acc(0, 2, 1, 0);
    expect_resp("R5 32-bit style trap", T2_32, 6'h05, 32'd0);
    quiet(); lvl2Enabled = 1; lvl2Is64 = 0; l2ExcTrap64 = 1;
    acc(0, 2, 1, 0);
    expect_resp("R5 64-bit bits ignored in 32 style", DOIT, 6'd0, 32'hA5A5_1234);
    quiet(); lvl2Enabled = 0; l2AccTrap64 = 1; lvl2Is64 = 1;
    acc(0, 2, 1, 0);
    expect_resp("R4 level2 disabled no trap", DOIT, 6'd0, 32'hA5A5_1234);
  endtask

  task automatic t_l3trap();
    quiet(); lvl3Present = 1; lvl3Is64 = 1; l3AccTrap = 1;
    acc(0, 2, 1, 0);
    expect_resp("R6 level3 trap from level1", T3, 6'h05, 32'd0);
    secDbgOff = 1;
    acc(0, 2, 2, 0);
    expect_resp("R6 secure debug off gives undef", UNDEF, 6'd0, 32'd0);
    quiet(); lvl3Present = 1; lvl3Is64 = 0; l3AccTrap = 1;
    acc(0, 2, 2, 0);
    expect_resp("R6 32-bit level3 no trap", DOIT, 6'd0, 32'hA5A5_1234);
  endtask

  task automatic t_halt();
    quiet(); osLocked = 0; haltAllowed = 1; extDbgTrap = 1;
    acc(1, 2, 1, 32'h7777_7777);
    expect_resp("R7 halt at level1", HALT, 6'd0, 32'd0);
    readback("R7 R10 halted write dropped", 2, 32'hA5A5_1234);
    quiet(); osLocked = 1; haltAllowed = 1; extDbgTrap = 1;
    acc(0, 2, 1, 0);
    expect_resp("R7 os lock blocks halt", DOIT, 6'd0, 32'hA5A5_1234);
  endtask

  task automatic t_levels();
    quiet(); lvl2Enabled = 1; lvl2Is64 = 1; l2AccTrap64 = 1;
    acc(0, 2, 2, 0);
    expect_resp("R8 level2 ignores l2 bits", DOIT, 6'd0, 32'hA5A5_1234);
    quiet(); lvl3Present = 1; lvl3Is64 = 1; l3AccTrap = 1; undefFirst = 1;
    acc(0, 2, 3, 0);
    expect_resp("R8 level3 ignores l3 trap", DOIT, 6'd0, 32'hA5A5_1234);
    osLocked = 0; haltAllowed = 1; extDbgTrap = 1;
    acc(0, 2, 3, 0);
    expect_resp("R8 level3 halt", HALT, 6'd0, 32'd0);
  endtask

  task automatic t_encoding();
    quiet(); opcB = 3'd5;
    acc(1, 2, 3, 32'h5555_5555);
    chk("R9 opc2 mismatch no response", 64'(respValid), 64'd0);
    quiet(); coprocNum = 4'hF;
    acc(1, 2, 3, 32'h6666_6666);
    chk("R9 coproc mismatch no response", 64'(respValid), 64'd0);
    readback("R9 storage unchanged", 2, 32'hA5A5_1234);
    @(negedge clk);
    chk("R11 valid drops after one cycle", 64'(respValid), 64'd0);
  endtask

  initial begin
    quiet();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_perform();
    t_gate();
    t_el0();
    t_early();
    t_l2trap();
    t_l3trap();
    t_halt();
    t_levels();
    t_encoding();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R11 watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule